// File: doc/BRIEF.md
# Routed Interrupt Controller

This block collects 32 interrupt inputs and presents them as a 4 by 4 grid of parent interrupt lines, one row of four lines for each of up to four cores. Every source first passes through a two-flop synchronizer. It is then qualified by its own trigger setting, which is level or edge with either polarity. The result is a per-source pending flag. A source that is enabled and pending drives the parent line chosen by its routing byte.

Software works through a small synchronous register bus. Each source has a routing byte at the byte offset equal to its source number. Enable bits are set and cleared through two separate write-one ports, and the current enable word reads back at its own offset. The polarity and trigger-mode words are plain read/write words. Pending status for all sources reads as one word. Writing ones to the pending word clears latched edges. Reads return data on the cycle after the read strobe.

Top module: `rirq_ctrl`

## Requirements
- R1: After reset the enable word (0x24) and the trigger-mode word (0x34) read 0, the polarity word (0x30) reads all ones, every routing byte reads 0, and every parent output is low.
- R2: A write to offset s (0x00 to 0x1F) stores bus_wdata[7:0] as the routing byte of source s. A read of offset s returns that byte zero-extended. Upper write-data bits are dropped.
- R3: Writing to 0x28 sets the enable bits where the data has ones, and writing to 0x2C clears them. Zero bits leave enables unchanged in both cases. The enable word reads back at 0x24.
- R4: The polarity word (0x30) and the trigger-mode word (0x34) read back what was last written. Read data appears on the cycle after bus_re.
- R5: A source in level mode (mode bit 0) is pending while its synchronized input equals its polarity bit (1 = active-high, 0 = active-low). An input change presented before clock edge k shows on the parent output after edge k+1.
- R6: A source in edge mode (mode bit 1) latches pending on a rising edge when its polarity bit is 1 and on a falling edge when it is 0. The latch holds after the input returns, and edges in the other direction are ignored.
- R7: Writing ones to 0x40 clears the matching edge latches. Such a write leaves level-mode pending unchanged. An edge that arrives in the same cycle as its clear wins, so the latch stays set.
- R8: The pending word at 0x40 shows every source's pending flag whether or not the source is enabled.
- R9: In a routing byte, bits 7:4 select the parent line (bit 4+L for line L) and bits 3:0 select the core (bit C for core C). Output irq_out[C*4+L] is the OR of all sources that are enabled, pending and routed to core C and line L.
- R10: A source whose line nibble or core nibble is zero drives no output, and a disabled source drives no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_re | input | 1 | Read strobe |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| src_in | input | 32 | Raw interrupt inputs, asynchronous |
| irq_out | output | 16 | Parent lines, index core*4+line |

## Verification
Two events can meet in one cycle: a freshly detected edge setting a source's latch, and a software write-one-to-clear on the pending word. The bench raises an edge-mode input and then counts the synchronizer and edge-detector stages. It times the clear write so that the write is sampled on the same clock edge that sets the latch. It then reads the pending word and expects the bit still set. A second clear with no new edge must then empty it. The remaining checks sweep every source across all sixteen core and line pairs, and cover several raw and polarity patterns in level mode.

// File: rtl/rirq_pkg.sv
package rirq_pkg;
  localparam int unsigned ROUTE_W = 8;
  localparam int unsigned NIB_W   = 4;

  localparam logic [7:0] OFS_EN_STAT = 8'h24;
  localparam logic [7:0] OFS_EN_SET  = 8'h28;
  localparam logic [7:0] OFS_EN_CLR  = 8'h2C;
  localparam logic [7:0] OFS_POL     = 8'h30;
  localparam logic [7:0] OFS_MODE    = 8'h34;
  localparam logic [7:0] OFS_PEND    = 8'h40;

  // Level qualification: the input sits at its active level.
  function automatic logic level_active(input logic lvl, input logic pol);
    return lvl == pol;
  endfunction

  // Edge qualification: rising when pol=1, falling when pol=0.
  function automatic logic edge_seen(input logic cur, input logic prev, input logic pol);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Routing byte: high nibble selects line, low nibble selects core.
  function automatic logic route_hit(input logic [ROUTE_W-1:0] rt,
                                     input int unsigned core, input int unsigned line);
    return rt[NIB_W + line] & rt[core];
  endfunction
endpackage

// File: rtl/rirq_sync.sv
module rirq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] st1_q, st2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= d_in;
      st2_q <= st1_q;
    end
  end

  assign q_out = st2_q;
endmodule

// File: rtl/rirq_src_detect.sv
module rirq_src_detect
  import rirq_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] sync_in,
  input  logic [N_SRC-1:0] mode,
  input  logic [N_SRC-1:0] pol,
  input  logic [N_SRC-1:0] clr_req,
  output logic [N_SRC-1:0] edge_evt,
  output logic [N_SRC-1:0] latch,
  output logic [N_SRC-1:0] pend
);
  logic [N_SRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_in;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign edge_evt[i] = mode[i] & edge_seen(sync_in[i], prev_q[i], pol[i]);

    always_ff @(posedge clk) begin
      if (!rst_n)           latch[i] <= 1'b0;
      else if (!mode[i])    latch[i] <= 1'b0;
      else if (edge_evt[i]) latch[i] <= 1'b1;
      else if (clr_req[i])  latch[i] <= 1'b0;
    end

    assign pend[i] = mode[i] ? latch[i] : level_active(sync_in[i], pol[i]);

    // R6: a detected edge in edge mode is held in the latch
    a_r6_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[i] |=> (latch[i] || !mode[i]));
    // R7: an edge wins over a clear in the same cycle
    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_evt[i] && clr_req[i] && mode[i]) |=> (latch[i] || !mode[i]));
    // R7: a clear without an edge empties the latch
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[i] && !edge_evt[i]) |=> !latch[i]);
    // R5: level mode keeps no latched state
    a_r5_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[i] && $past(!mode[i])) |-> !latch[i]);
  end
endmodule

// File: rtl/rirq_regs.sv
module rirq_regs
  import rirq_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned AW    = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_re,
  input  logic                            bus_we,
  input  logic [AW-1:0]                   bus_addr,
  input  logic [N_SRC-1:0]                bus_wdata,
  output logic [N_SRC-1:0]                bus_rdata,
  input  logic [N_SRC-1:0]                pend,
  output logic [N_SRC-1:0]                en_q,
  output logic [N_SRC-1:0]                pol_q,
  output logic [N_SRC-1:0]                mode_q,
  output logic [N_SRC-1:0]                clr_req,
  output logic [N_SRC-1:0][ROUTE_W-1:0]   route_q
);
  localparam int unsigned SIW       = $clog2(N_SRC);
  localparam logic [AW-1:0] ROUTE_LIM = AW'(N_SRC);

  logic            hit_route;
  logic [SIW-1:0]  sidx;
  logic [N_SRC-1:0] rd_mux;

  assign hit_route = bus_addr < ROUTE_LIM;
  assign sidx      = bus_addr[SIW-1:0];
  assign clr_req   = (bus_we && bus_addr == AW'(OFS_PEND)) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '1;
      mode_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == AW'(OFS_EN_SET)) en_q   <= en_q | bus_wdata;
      if (bus_addr == AW'(OFS_EN_CLR)) en_q   <= en_q & ~bus_wdata;
      if (bus_addr == AW'(OFS_POL))    pol_q  <= bus_wdata;
      if (bus_addr == AW'(OFS_MODE))   mode_q <= bus_wdata;
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_route
    always_ff @(posedge clk) begin
      if (!rst_n)
        route_q[s] <= '0;
      else if (bus_we && hit_route && sidx == SIW'(s))
        route_q[s] <= bus_wdata[ROUTE_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_route) rd_mux = {{(N_SRC-ROUTE_W){1'b0}}, route_q[sidx]};
    else begin
      case (bus_addr)
        AW'(OFS_EN_STAT): rd_mux = en_q;
        AW'(OFS_POL):     rd_mux = pol_q;
        AW'(OFS_MODE):    rd_mux = mode_q;
        AW'(OFS_PEND):    rd_mux = pend;
        default:          rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  // R3: set port raises every written one
  a_r3_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFS_EN_SET)) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));
  // R3: clear port drops every written one
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFS_EN_CLR)) |=> ((en_q & $past(bus_wdata)) == '0));
  // R2: routing bytes move only on a write
  a_r2_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(route_q));
  // R4: read data changes only after a read strobe
  a_r4_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
endmodule

// File: rtl/rirq_route.sv
module rirq_route
  import rirq_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_CORE = 4,
  parameter int unsigned N_LINE = 4
) (
  input  logic [N_SRC-1:0]               en,
  input  logic [N_SRC-1:0]               pend,
  input  logic [N_SRC-1:0][ROUTE_W-1:0]  route,
  output logic [N_CORE*N_LINE-1:0]       irq
);
  logic [N_SRC-1:0] live;
  assign live = en & pend;

  for (genvar c = 0; c < N_CORE; c++) begin : g_core
    for (genvar l = 0; l < N_LINE; l++) begin : g_line
      always_comb begin
        irq[c*N_LINE+l] = 1'b0;
        for (int s = 0; s < N_SRC; s++)
          irq[c*N_LINE+l] = irq[c*N_LINE+l] | (live[s] & route_hit(route[s], c, l));
      end
    end
  end
endmodule

// File: rtl/rirq_ctrl.sv
module rirq_ctrl
  import rirq_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_CORE = 4,
  parameter int unsigned N_LINE = 4,
  parameter int unsigned AW     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_re,
  input  logic                       bus_we,
  input  logic [AW-1:0]              bus_addr,
  input  logic [N_SRC-1:0]           bus_wdata,
  output logic [N_SRC-1:0]           bus_rdata,
  input  logic [N_SRC-1:0]           src_in,
  output logic [N_CORE*N_LINE-1:0]   irq_out
);
  logic [N_SRC-1:0] sync_lvl, en_q, pol_q, mode_q, clr_req;
  logic [N_SRC-1:0] edge_evt, latch, pend;
  logic [N_SRC-1:0][ROUTE_W-1:0] route_q;

  rirq_sync #(.W(N_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(src_in), .q_out(sync_lvl)
  );

  rirq_regs #(.N_SRC(N_SRC), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend(pend), .en_q(en_q), .pol_q(pol_q), .mode_q(mode_q),
    .clr_req(clr_req), .route_q(route_q)
  );

  rirq_src_detect #(.N_SRC(N_SRC)) u_detect (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_lvl), .mode(mode_q), .pol(pol_q),
    .clr_req(clr_req), .edge_evt(edge_evt), .latch(latch), .pend(pend)
  );

  rirq_route #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_LINE(N_LINE)) u_route (
    .en(en_q), .pend(pend), .route(route_q), .irq(irq_out)
  );

  // R10: with no source enabled every parent line is low
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (irq_out == '0));
  // R9: a raised parent line needs some enabled pending source
  a_r9_needs_live_source: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |-> ((en_q & pend) != '0));
endmodule

// File: tb/rirq_ctrl_bench.sv
`timescale 1ns/1ps
module rirq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_re = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_in = '0;
  logic [15:0] irq_out;
  int n_chk = 0, n_err = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  rirq_ctrl u_rirq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rdr(8'h24, rd); chk("R1 enable", rd, 32'h0);
    rdr(8'h34, rd); chk("R1 mode", rd, 32'h0);
    rdr(8'h30, rd); chk("R1 polarity", rd, 32'hFFFF_FFFF);
    rdr(8'h05, rd); chk("R1 route", rd, 32'h0);
    chk("R1 irq", {16'h0, irq_out}, 32'h0);
    rdr(8'h40, rd); chk("R1 pending", rd, 32'h0);

    // R2 routing bytes, upper data bits dropped
    for (int s = 0; s < 32; s++) wr(8'(s), {24'hABCDEF, 8'((s*37+11) & 255)});
    for (int s = 0; s < 32; s++) begin
      rdr(8'(s), rd); chk("R2 route readback", rd, 32'((s*37+11) & 255));
    end
    for (int s = 0; s < 32; s++) wr(8'(s), 32'h0);

    // R3 enable set/clear
    wr(8'h28, 32'hA5A5_0F0F); rdr(8'h24, rd); chk("R3 set", rd, 32'hA5A5_0F0F);
    wr(8'h28, 32'h0000_F000); rdr(8'h24, rd); chk("R3 set or", rd, 32'hA5A5_FF0F);
    wr(8'h2C, 32'h0505_0003); rdr(8'h24, rd); chk("R3 clear", rd, 32'hA0A0_FF0C);
    wr(8'h2C, 32'hFFFF_FFFF); rdr(8'h24, rd); chk("R3 clear all", rd, 32'h0);

    // R4 polarity and mode words
    wr(8'h30, 32'h1234_5678); rdr(8'h30, rd); chk("R4 polarity", rd, 32'h1234_5678);
    wr(8'h34, 32'h0F0F_00FF); rdr(8'h34, rd); chk("R4 mode", rd, 32'h0F0F_00FF);
    wr(8'h34, 32'h0);

    // R5/R8 level pending across raw x polarity patterns, sources disabled
    for (int p = 0; p < 3; p++) begin
      logic [31:0] pv;
      pv = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 : 32'h00FF_FF00;
      wr(8'h30, pv);
      for (int r = 0; r < 4; r++) begin
        logic [31:0] rv;
        rv = (r == 0) ? 32'h8000_0001 : (r == 1) ? 32'h0 : (r == 2) ? 32'hFFFF_FFFF : 32'h3C96_A55A;
        src_in = rv;
        tick(3);
        rdr(8'h40, rd); chk("R5 R8 level pending", rd, ~(rv ^ pv));
      end
    end
    src_in = '0;
    wr(8'h30, 32'hFFFF_FFFF);
    tick(3);

    // R5 exact latency: source 0 on core 0 line 0
    wr(8'h00, 32'h11);
    wr(8'h28, 32'h1);
    src_in[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R5 latency early", {16'h0, irq_out}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R5 latency on", {16'h0, irq_out}, 32'h1);
    src_in[0] = 1'b0;
    wr(8'h2C, 32'hFFFF_FFFF); wr(8'h00, 32'h0);
    tick(3);

    // R6 edge capture: low half rising, high half falling
    wr(8'h30, 32'h0000_FFFF);
    src_in = 32'hFFFF_0000;
    tick(4);
    wr(8'h34, 32'hFFFF_FFFF);
    tick(2);
    rdr(8'h40, rd); chk("R6 no edge yet", rd, 32'h0);
    src_in = 32'h0000_FFFF;
    tick(4);
    rdr(8'h40, rd); chk("R6 edges latched", rd, 32'hFFFF_FFFF);
    src_in = 32'hFFFF_0000;
    tick(4);
    rdr(8'h40, rd); chk("R6 latch holds", rd, 32'hFFFF_FFFF);
    wr(8'h40, 32'h0000_00FF);
    rdr(8'h40, rd); chk("R7 partial clear", rd, 32'hFFFF_FF00);
    wr(8'h40, 32'hFFFF_FFFF);
    rdr(8'h40, rd); chk("R7 clear all", rd, 32'h0);

    // R7 edge and clear in the same cycle: source 2 rising
    @(negedge clk); src_in[2] = 1'b1;      // before edge k
    @(negedge clk);                          // after k: stage 1
    @(negedge clk);                          // after k+1: event visible
    bus_we = 1'b1; bus_addr = 8'h40; bus_wdata = 32'h4;
    @(negedge clk);                          // sampled at k+2 with the set
    bus_we = 1'b0;
    rdr(8'h40, rd); chk("R7 edge wins over clear", rd, 32'h4);
    wr(8'h40, 32'h4);
    rdr(8'h40, rd); chk("R7 clear after race", rd, 32'h0);

    // R7 clear has no effect on level mode
    wr(8'h34, 32'h0); wr(8'h30, 32'hFFFF_FFFF);
    src_in = 32'h0000_00F0;
    tick(4);
    wr(8'h40, 32'hFFFF_FFFF);
    rdr(8'h40, rd); chk("R7 level unaffected", rd, 32'h0000_00F0);
    src_in = '0;
    tick(3);

    // R9 sweep: every source over every core/line pair
    for (int s = 0; s < 32; s++) begin
      wr(8'h28, 32'(1) << s);
      src_in = 32'(1) << s;
      tick(3);
      for (int c = 0; c < 4; c++)
        for (int l = 0; l < 4; l++) begin
          wr(8'(s), 32'(((1 << l) << 4) | (1 << c)));
          chk("R9 route sweep", {16'h0, irq_out}, 32'(1) << (c*4 + l));
        end
      wr(8'(s), 32'h0);
      chk("R10 zero route", {16'h0, irq_out}, 32'h0);
      wr(8'h2C, 32'(1) << s);
      src_in = '0;
      tick(3);
    end

    // R10 half-zero nibbles and disabled source; R9 OR of two sources
    src_in = 32'h0000_0300;
    wr(8'h28, 32'h0000_0300);
    tick(3);
    wr(8'h08, 32'h04);
    chk("R10 line nibble zero", {16'h0, irq_out}, 32'h0);
    wr(8'h08, 32'h40);
    chk("R10 core nibble zero", {16'h0, irq_out}, 32'h0);
    wr(8'h08, 32'h42); wr(8'h09, 32'h42);
    chk("R9 two sources", {16'h0, irq_out}, 32'h0000_0040);
    wr(8'h2C, 32'h0000_0100);
    chk("R9 one left", {16'h0, irq_out}, 32'h0000_0040);
    wr(8'h2C, 32'h0000_0200);
    chk("R10 disabled", {16'h0, irq_out}, 32'h0);
    rdr(8'h40, rd); chk("R8 pending while disabled", rd, 32'h0000_0300);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule